// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers the per-channel interrupt events of a multi-channel DMA engine and presents them to software through a small memory-mapped register window. Every channel can signal three independent event classes: transfer done, error class one and error class two. Each class has a sticky raw latch, a mask that enables individual channels, and a masked view that is the AND of the two. A combined status word flags every channel that has any enabled event pending. A single interrupt line is raised while that word is nonzero.

Software acknowledges an event by writing 1 to its bit in the matching raw latch. A new event pulse that arrives in the same cycle as the acknowledge wins, so no event is lost. The block also samples a per-channel busy vector for software to read, and it holds a read/write channel priority word. Register reads are registered: `reg_rdata` shows the value addressed at the previous clock edge.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After a synchronous reset every register reads 0 and `irq_out` is 0.
- R2: A one-cycle pulse on bit i of an event input sets bit i of that class's raw latch (done at 0x600, error-1 at 0x610, error-2 at 0x618), and the bit stays set until cleared.
- R3: Writing a raw latch address clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a write-1 clear hit the same raw bit in the same cycle, the bit ends up set.
- R5: The mask words (done 0x18, error-1 0x20, error-2 0x24) are read/write, N bits wide; a mask bit of 1 enables that channel's event.
- R6: The masked words (done 0x04, error-1 0x0C, error-2 0x10) read raw AND mask for their class and ignore writes.
- R7: Bit i of the combined status word at 0x00 is the OR of channel i's three masked bits; writes to it are ignored.
- R8: `irq_out` is 1 exactly one clock after the combined status word is nonzero, and 0 one clock after it is zero.
- R9: The busy word at 0x690 reads the `chan_busy` input as registered one clock earlier; writes to it are ignored.
- R10: The priority word at 0x688 is read/write over its low N bits, upper bits read 0.
- R11: Reads of any unmapped address return 0, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | N | Per-channel transfer-done pulses |
| evt_err1 | input | N | Per-channel error class one pulses |
| evt_err2 | input | N | Per-channel error class two pulses |
| chan_busy | input | N | Per-channel active flags |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for the previous address |
| irq_out | output | 1 | Interrupt request, high while any enabled event is pending |

## Verification
The latches are driven with single-channel pulses, multi-bit patterns in one class and scattered events spread over all three classes, so that a bit landing in the wrong class or wrong channel shows in the raw read-back. Clears are tried with all-zero, partial and full write masks, and once in the same cycle as a fresh pulse, which separates set-priority from clear-priority. Masks are swept between all-enabled, all-disabled and a single disabled channel, which tells an AND from an OR in the masked views and shows whether the combined word and the interrupt follow the enabled events only. Writes to read-only and unmapped addresses are followed by reads of the state they could have disturbed.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int NCLS = 3;

  typedef enum logic [1:0] {
    CLS_DONE = 2'd0,
    CLS_ERR1 = 2'd1,
    CLS_ERR2 = 2'd2
  } evt_cls_e;

  localparam logic [11:0] OFS_STATUS = 12'h000;
  localparam logic [11:0] OFS_PRIO   = 12'h688;
  localparam logic [11:0] OFS_BUSY   = 12'h690;

  function automatic logic [11:0] raw_ofs(input int cls);
    case (cls)
      0:       raw_ofs = 12'h600;
      1:       raw_ofs = 12'h610;
      default: raw_ofs = 12'h618;
    endcase
  endfunction

  function automatic logic [11:0] mask_ofs(input int cls);
    case (cls)
      0:       mask_ofs = 12'h018;
      1:       mask_ofs = 12'h020;
      default: mask_ofs = 12'h024;
    endcase
  endfunction

  function automatic logic [11:0] masked_ofs(input int cls);
    case (cls)
      0:       masked_ofs = 12'h004;
      1:       masked_ofs = 12'h00C;
      default: masked_ofs = 12'h010;
    endcase
  endfunction

endpackage

// File: rtl/dma_irq_evtclass.sv
module dma_irq_evtclass #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] masked
);

  logic [N-1:0] clr_bits;

  assign clr_bits = clr_we ? wbits : '0;

  // a fresh pulse is ORed in after the clear, so it wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | evt;
      if (mask_we) mask_q <= wbits;
    end
  end

  assign masked = raw_q & mask_q;

endmodule

// File: rtl/dma_irq_wrdec.sv
module dma_irq_wrdec
  import dma_irq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  output logic [NCLS-1:0] clr_we,
  output logic [NCLS-1:0] mask_we,
  output logic            prio_we
);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign clr_we[c]  = wr_en && (addr == AW'(raw_ofs(c)));
    assign mask_we[c] = wr_en && (addr == AW'(mask_ofs(c)));
  end

  assign prio_we = wr_en && (addr == AW'(OFS_PRIO));

endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic [AW-1:0]           addr,
  input  logic [NCLS-1:0][N-1:0]  raw,
  input  logic [NCLS-1:0][N-1:0]  mask,
  input  logic [NCLS-1:0][N-1:0]  masked,
  input  logic [N-1:0]            status,
  input  logic [N-1:0]            busy,
  input  logic [N-1:0]            prio,
  output logic [DW-1:0]           rdata
);

  logic [NCLS-1:0][DW-1:0] raw_sel, mask_sel, masked_sel;

  for (genvar c = 0; c < NCLS; c++) begin : g_sel
    assign raw_sel[c]    = (addr == AW'(raw_ofs(c)))    ? DW'(raw[c])    : '0;
    assign mask_sel[c]   = (addr == AW'(mask_ofs(c)))   ? DW'(mask[c])   : '0;
    assign masked_sel[c] = (addr == AW'(masked_ofs(c))) ? DW'(masked[c]) : '0;
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCLS; c++) begin
      rdata = rdata | raw_sel[c] | mask_sel[c] | masked_sel[c];
    end
    if (addr == AW'(OFS_STATUS)) rdata = rdata | DW'(status);
    if (addr == AW'(OFS_BUSY))   rdata = rdata | DW'(busy);
    if (addr == AW'(OFS_PRIO))   rdata = rdata | DW'(prio);
  end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import dma_irq_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt_done,
  input  logic [N-1:0]  evt_err1,
  input  logic [N-1:0]  evt_err2,
  input  logic [N-1:0]  chan_busy,
  input  logic          reg_wr_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_out
);

  logic [NCLS-1:0][N-1:0] evt_vec, raw_vec, mask_vec, masked_vec;
  logic [NCLS-1:0]        clr_we, mask_we;
  logic                   prio_we;
  logic [N-1:0]           status_all, busy_q, prio_q;
  logic [DW-1:0]          rdata_d;
  logic                   unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata;

  assign evt_vec[CLS_DONE] = evt_done;
  assign evt_vec[CLS_ERR1] = evt_err1;
  assign evt_vec[CLS_ERR2] = evt_err2;

  dma_irq_wrdec #(.AW(AW)) u_wrdec (
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .clr_we  (clr_we),
    .mask_we (mask_we),
    .prio_we (prio_we)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_class
    dma_irq_evtclass #(.N(N)) u_cls (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_vec[c]),
      .clr_we  (clr_we[c]),
      .mask_we (mask_we[c]),
      .wbits   (reg_wdata[N-1:0]),
      .raw_q   (raw_vec[c]),
      .mask_q  (mask_vec[c]),
      .masked  (masked_vec[c])
    );
  end

  always_comb begin
    status_all = '0;
    for (int c = 0; c < NCLS; c++) status_all = status_all | masked_vec[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= '0;
      prio_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      busy_q  <= chan_busy;
      irq_out <= |status_all;
      if (prio_we) prio_q <= reg_wdata[N-1:0];
    end
  end

  dma_irq_rdmux #(.N(N), .DW(DW), .AW(AW)) u_rdmux (
    .addr   (reg_addr),
    .raw    (raw_vec),
    .mask   (mask_vec),
    .masked (masked_vec),
    .status (status_all),
    .busy   (busy_q),
    .prio   (prio_q),
    .rdata  (rdata_d)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rdata_d;
  end

endmodule

// File: rtl/dma_irq_aggregator_chk.sv
module dma_irq_aggregator_chk
  import dma_irq_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  evt_done,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          irq_out,
  input logic [N-1:0]  raw_done,
  input logic [N-1:0]  mask_done,
  input logic [N-1:0]  status_all
);

  logic unused_chk_hi;
  assign unused_chk_hi = ^reg_wdata;

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_done != '0) |=> ((raw_done & $past(evt_done)) == $past(evt_done)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == AW'(raw_ofs(0)) && (reg_wdata[N-1:0] & evt_done) == '0)
    |=> ((raw_done & $past(reg_wdata[N-1:0])) == '0));

  // R8
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == ($past(status_all) != '0)));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_addr == AW'(mask_ofs(0))) |=> $stable(mask_done));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == AW'(raw_ofs(0)) && (reg_wdata[N-1:0] & evt_done) != '0)
    |=> ((raw_done & $past(reg_wdata[N-1:0] & evt_done)) == $past(reg_wdata[N-1:0] & evt_done)));

endmodule

bind dma_irq_aggregator dma_irq_aggregator_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_done   (evt_done),
  .reg_wr_en  (reg_wr_en),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .irq_out    (irq_out),
  .raw_done   (raw_vec[0]),
  .mask_done  (mask_vec[0]),
  .status_all (status_all)
);

// File: tb/dma_irq_aggregator_bench.sv
module dma_irq_aggregator_bench;

  localparam int N  = 16;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  evt_done = '0, evt_err1 = '0, evt_err2 = '0, chan_busy = '0;
  logic          reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_irq_aggregator #(.N(N), .DW(DW), .AW(AW)) u_dma_irq_aggregator (
    .clk(clk), .rst(rst), .evt_done(evt_done), .evt_err1(evt_err1),
    .evt_err2(evt_err2), .chan_busy(chan_busy), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int cls, input logic [N-1:0] bits);
    @(negedge clk);
    case (cls)
      0: evt_done = bits;
      1: evt_err1 = bits;
      default: evt_err2 = bits;
    endcase
    @(negedge clk);
    evt_done = '0; evt_err1 = '0; evt_err2 = '0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(12'h000, v); check("R1", "status after reset", v, 0);
    rd(12'h600, v); check("R1", "raw done after reset", v, 0);
    rd(12'h018, v); check("R1", "mask done after reset", v, 0);
    rd(12'h688, v); check("R1", "prio after reset", v, 0);
    check("R1", "irq after reset", {31'd0, irq_out}, 0);
  endtask

  task automatic t_latch();
    logic [DW-1:0] v;
    pulse(0, 16'h0005);
    repeat (3) @(negedge clk);
    rd(12'h600, v); check("R2", "raw done sticky", v, 32'h0005);
    rd(12'h610, v); check("R2", "raw err1 untouched", v, 0);
    rd(12'h004, v); check("R6", "masked done with mask 0", v, 0);
    check("R8", "irq low while masked", {31'd0, irq_out}, 0);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] v;
    wr(12'h600, 32'h0004);
    rd(12'h600, v); check("R3", "clear bit2", v, 32'h0001);
    wr(12'h600, 32'h0000);
    rd(12'h600, v); check("R3", "write zero keeps", v, 32'h0001);
    wr(12'h600, 32'hFFFF);
    rd(12'h600, v); check("R3", "clear all", v, 0);
  endtask

  task automatic t_collision();
    logic [DW-1:0] v;
    pulse(1, 16'h0018);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 12'h610; reg_wdata = 32'h0018; evt_err1 = 16'h0008;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0; evt_err1 = '0;
    rd(12'h610, v); check("R4", "pulse beats clear", v, 32'h0008);
  endtask

  task automatic t_masks();
    logic [DW-1:0] v;
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, v); check("R5", "mask err1 readback", v, 32'hFFFF);
    rd(12'h00C, v); check("R6", "masked err1 enabled", v, 32'h0008);
    wr(12'h020, 32'h0000_FFF7);
    rd(12'h00C, v); check("R6", "masked err1 bit3 disabled", v, 0);
    wr(12'h00C, 32'hFFFF);
    rd(12'h610, v); check("R6", "write to masked view ignored", v, 32'h0008);
  endtask

  task automatic t_combined();
    logic [DW-1:0] v;
    wr(12'h018, 32'hFFFF);
    wr(12'h020, 32'hFFFF);
    wr(12'h024, 32'hFFFF);
    pulse(0, 16'h0002);
    pulse(2, 16'h8000);
    rd(12'h000, v); check("R7", "combined three classes", v, 32'h800A);
    check("R8", "irq high", {31'd0, irq_out}, 1);
    wr(12'h024, 32'h7FFF);
    rd(12'h000, v); check("R7", "combined with err2 ch15 masked", v, 32'h000A);
    wr(12'h000, 32'hFFFF);
    rd(12'h600, v); check("R7", "status write ignored", v, 32'h0002);
    wr(12'h600, 32'hFFFF);
    wr(12'h610, 32'hFFFF);
    wr(12'h618, 32'hFFFF);
    rd(12'h000, v); check("R7", "combined after clears", v, 0);
    @(negedge clk);
    check("R8", "irq low after clears", {31'd0, irq_out}, 0);
  endtask

  task automatic t_busy();
    logic [DW-1:0] v;
    @(negedge clk); chan_busy = 16'hA5A5;
    repeat (2) @(negedge clk);
    rd(12'h690, v); check("R9", "busy sampled", v, 32'hA5A5);
    wr(12'h690, 32'h0000);
    rd(12'h690, v); check("R9", "busy write ignored", v, 32'hA5A5);
  endtask

  task automatic t_prio();
    logic [DW-1:0] v;
    wr(12'h688, 32'h0000_1234);
    rd(12'h688, v); check("R10", "prio readback", v, 32'h1234);
    wr(12'h688, 32'hFFFF_FFFF);
    rd(12'h688, v); check("R10", "prio upper bits zero", v, 32'hFFFF);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    wr(12'h008, 32'hFFFF);
    rd(12'h008, v); check("R11", "unmapped read", v, 0);
    wr(12'h604, 32'h0000);
    rd(12'h604, v); check("R11", "unmapped 0x604 read", v, 0);
    rd(12'h018, v); check("R11", "mask done unchanged", v, 32'hFFFF);
    rd(12'h688, v); check("R11", "prio unchanged", v, 32'hFFFF);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latch();
    t_w1c();
    t_collision();
    t_masks();
    t_combined();
    t_busy();
    t_prio();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule